// File: doc/BRIEF.md
# SDRAM Read Burst Truncation Scheduler

This block sends the SDRAM command sequence for one read to a row that is already open, and it cuts the burst off after a requested number of data beats. A client presents a request with a bank, a column, the number of beats it wants, the way the burst should end and an auto-precharge flag. The block drives the READ command. It then places the ending command so that the last wanted beat is the last one captured. The ending command is either a bank precharge or a burst terminate.

The ending command goes out CAS latency minus one cycles before the cycle in which the last wanted beat is valid. For N wanted beats this is always N cycles after the READ, whatever the CAS latency. As a result, the precharge overlaps the tail of the returning data. A capture strobe marks each wanted beat at the data pins. The request handshake stays closed until the bank can legally take the next command.

The CAS latency and the burst mode (fixed length of four, or full page) are static configuration inputs. They are changed only while the block is idle.

Top module: `rd_trunc_sched`

## Requirements
- R1: While the reset is applied and after it is released, req_ready is high, sd_cmd is NOP (0111 on {CS#,RAS#,CAS#,WE#}), sd_addr and sd_ba are zero, and rd_capture is low.
- R2: An accepted request puts READ (0101) on sd_cmd in the cycle after the accepting edge. In that cycle, sd_ba carries the bank, sd_addr[7:0] carries the column, and sd_addr[10] equals the auto-precharge flag. All other address bits are zero.
- R3: In precharge mode with N effective beats, PRECHARGE (0010) goes out exactly N cycles after the READ cycle, which is CAS latency minus one cycles before the last wanted beat. It carries the same bank on sd_ba and has sd_addr all zero, so bit 10 is low and only that bank closes.
- R4: In terminate mode (req_end_bst=1), BURST TERMINATE (0110) goes out exactly N cycles after the READ cycle, with sd_addr and sd_ba zero.
- R5: rd_capture is high for exactly N consecutive cycles, starting CL cycles after the READ cycle. CL is 3 when cfg_cas_lat is 3 and 2 for any other value.
- R6: With cfg_full_page low, a beat count above 4 is clamped to 4. With cfg_full_page high, the beat count is used as given.
- R7: With auto precharge, N is 4 whatever the requested count. The cycle where the ending command would fall carries NOP instead, and req_ready returns in the same cycle as for an explicit precharge after a complete burst of four. No cycle is added.
- R8: req_ready is low from the READ cycle onward. After a PRECHARGE, it returns high TRP-1 cycles after the PRECHARGE cycle, so the next READ is at least TRP cycles after it. After a BURST TERMINATE, it is high again in the terminate cycle itself.
- R9: A request with a beat count of 0, or with auto precharge combined with terminate mode or with full-page mode, is refused. req_reject is high for one cycle after the accepting edge, no command is issued, and req_ready stays high.
- R10: Every cycle that carries no READ, PRECHARGE or BURST TERMINATE shows NOP with sd_addr and sd_ba zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_cas_lat | input | 2 | CAS latency setting: 3 selects three cycles, anything else selects two |
| cfg_full_page | input | 1 | 1 = full-page bursts, 0 = fixed bursts of four |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken at this edge |
| req_bank | input | 2 | Target bank |
| req_col | input | 8 | Start column |
| req_beats | input | 8 | Number of wanted data beats |
| req_end_bst | input | 1 | 1 = end with burst terminate, 0 = end with precharge |
| req_autopre | input | 1 | Request auto precharge on the READ |
| req_reject | output | 1 | One-cycle pulse when an illegal request was refused |
| sd_cmd | output | 4 | Command as {CS#,RAS#,CAS#,WE#} |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 13 | Address bus |
| rd_capture | output | 1 | High in each cycle a wanted beat is valid on the data pins |

## Verification
The bench targets single-beat reads, where the ending command directly follows the READ. A design off by one on the end counter would let an extra beat through or drop the only one. The bench also runs both CAS latencies against the same beat counts. A design that tied the ending command to the latency would move it while the strobe stayed put. Requests above four beats in fixed mode and auto-precharge reads must show the clamp and the missing end command, with recovery timing identical to a complete explicit precharge. Refused requests must leave the command bus idle and the handshake open. A design that accepted them would issue a READ whose burst the bank cannot end legally.

// File: rtl/rts_pkg.sv
package rts_pkg;
  typedef enum logic [3:0] {
    CMD_NOP  = 4'b0111,
    CMD_READ = 4'b0101,
    CMD_PRE  = 4'b0010,
    CMD_BST  = 4'b0110
  } sd_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_BURST,
    ST_RECOV
  } seq_st_e;
endpackage

// File: rtl/rts_req_check.sv
module rts_req_check #(
  parameter int BEAT_W    = 8,
  parameter int BURST_LEN = 4
) (
  input  logic [BEAT_W-1:0] beats_i,
  input  logic              bst_i,
  input  logic              ap_i,
  input  logic              full_page_i,
  output logic              reject_o,
  output logic [BEAT_W-1:0] eff_beats_o
);
  localparam logic [BEAT_W-1:0] BL = BEAT_W'(BURST_LEN);

  always_comb begin
    reject_o = (beats_i == '0) || (ap_i && (bst_i || full_page_i));
    if (ap_i)
      eff_beats_o = BL;
    else if (!full_page_i && (beats_i > BL))
      eff_beats_o = BL;
    else
      eff_beats_o = beats_i;
  end
endmodule

// File: rtl/rts_seq.sv
module rts_seq
  import rts_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2,
  parameter int BEAT_W = 8,
  parameter int TRP    = 3,
  parameter int AP_BIT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_i,
  input  logic              rej_i,
  input  logic [BA_W-1:0]   bank_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic              bst_i,
  input  logic              ap_i,
  input  logic [BEAT_W-1:0] beats_i,
  output logic              ready_o,
  output logic              reject_o,
  output logic [3:0]        cmd_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              beat_o
);
  localparam int RC_W    = (TRP > 2) ? $clog2(TRP) : 1;
  localparam int RC_LOAD = (TRP >= 2) ? TRP - 2 : 0;

  seq_st_e           st_q, st_d;
  logic [BEAT_W-1:0] cnt_q, cnt_d, n_q, n_d;
  logic [BA_W-1:0]   bank_q, bank_d;
  logic              bst_q, bst_d, ap_q, ap_d;
  logic [RC_W-1:0]   rc_q, rc_d;
  sd_cmd_e           cmd_q, cmd_d;
  logic [BA_W-1:0]   ba_q, ba_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              rej_q, rej_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    n_d    = n_q;
    bank_d = bank_q;
    bst_d  = bst_q;
    ap_d   = ap_q;
    rc_d   = rc_q;
    cmd_d  = CMD_NOP;
    ba_d   = '0;
    addr_d = '0;
    rej_d  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        rej_d = rej_i;
        if (acc_i) begin
          st_d   = ST_BURST;
          cnt_d  = '0;
          n_d    = beats_i;
          bank_d = bank_i;
          bst_d  = bst_i;
          ap_d   = ap_i;
          cmd_d  = CMD_READ;
          ba_d   = bank_i;
          addr_d[COL_W-1:0] = col_i;
          addr_d[AP_BIT]    = ap_i;
        end
      end
      ST_BURST: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == n_q - 1'b1) begin
          if (bst_q) begin
            cmd_d = CMD_BST;
            st_d  = ST_IDLE;
          end else begin
            cmd_d = ap_q ? CMD_NOP : CMD_PRE;
            ba_d  = ap_q ? '0 : bank_q;
            if (TRP <= 1) begin
              st_d = ST_IDLE;
            end else begin
              st_d = ST_RECOV;
              rc_d = RC_W'(RC_LOAD);
            end
          end
        end
      end
      ST_RECOV: begin
        if (rc_q == '0) st_d = ST_IDLE;
        else            rc_d = rc_q - 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      n_q    <= '0;
      bank_q <= '0;
      bst_q  <= 1'b0;
      ap_q   <= 1'b0;
      rc_q   <= '0;
      cmd_q  <= CMD_NOP;
      ba_q   <= '0;
      addr_q <= '0;
      rej_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      n_q    <= n_d;
      bank_q <= bank_d;
      bst_q  <= bst_d;
      ap_q   <= ap_d;
      rc_q   <= rc_d;
      cmd_q  <= cmd_d;
      ba_q   <= ba_d;
      addr_q <= addr_d;
      rej_q  <= rej_d;
    end
  end

  assign ready_o  = (st_q == ST_IDLE);
  assign reject_o = rej_q;
  assign cmd_o    = cmd_q;
  assign ba_o     = ba_q;
  assign addr_o   = addr_q;
  assign beat_o   = (st_q == ST_BURST);

  // cycles since the last PRECHARGE, saturating; used only by the checks
  logic [7:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                gap_q <= 8'hFF;
    else if (cmd_q == CMD_PRE) gap_q <= 8'd1;
    else if (gap_q != 8'hFF)   gap_q <= gap_q + 8'd1;
  end

  p_trp_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_READ) |-> (gap_q >= 8'(TRP)));

  p_read_drops_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_READ) |-> !ready_o);

  p_bst_not_autopre_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_BST) |-> !ap_q);

  p_reject_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rej_q |-> (ready_o && cmd_q == CMD_NOP));

  p_cmd_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_NOP) |-> (addr_q == '0 && ba_q == '0));
endmodule

// File: rtl/rts_strobe.sv
module rts_strobe #(
  parameter int MAX_CL = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cl3_i,
  input  logic beat_i,
  output logic strobe_o
);
  logic [MAX_CL-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = {sr_q[MAX_CL-2:0], beat_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign strobe_o = cl3_i ? sr_q[2] : sr_q[1];

  p_strobe_lag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |-> (cl3_i ? $past(beat_i, 3) : $past(beat_i, 2)));
endmodule

// File: rtl/rd_trunc_sched.sv
module rd_trunc_sched #(
  parameter int COL_W     = 8,
  parameter int ADDR_W    = 13,
  parameter int BA_W      = 2,
  parameter int BEAT_W    = 8,
  parameter int BURST_LEN = 4,
  parameter int TRP       = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_cas_lat,
  input  logic              cfg_full_page,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BA_W-1:0]   req_bank,
  input  logic [COL_W-1:0]  req_col,
  input  logic [BEAT_W-1:0] req_beats,
  input  logic              req_end_bst,
  input  logic              req_autopre,
  output logic              req_reject,
  output logic [3:0]        sd_cmd,
  output logic [BA_W-1:0]   sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic              rd_capture
);
  logic [1:0]        rsync_q;
  logic              rst_int_n;
  logic              bad_req;
  logic [BEAT_W-1:0] eff_beats;
  logic              take, refuse, beat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  rts_req_check #(.BEAT_W(BEAT_W), .BURST_LEN(BURST_LEN)) u_chk (
    .beats_i     (req_beats),
    .bst_i       (req_end_bst),
    .ap_i        (req_autopre),
    .full_page_i (cfg_full_page),
    .reject_o    (bad_req),
    .eff_beats_o (eff_beats)
  );

  assign take   = req_valid && req_ready && !bad_req;
  assign refuse = req_valid && req_ready && bad_req;

  rts_seq #(
    .COL_W(COL_W), .ADDR_W(ADDR_W), .BA_W(BA_W), .BEAT_W(BEAT_W), .TRP(TRP)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .acc_i    (take),
    .rej_i    (refuse),
    .bank_i   (req_bank),
    .col_i    (req_col),
    .bst_i    (req_end_bst),
    .ap_i     (req_autopre),
    .beats_i  (eff_beats),
    .ready_o  (req_ready),
    .reject_o (req_reject),
    .cmd_o    (sd_cmd),
    .ba_o     (sd_ba),
    .addr_o   (sd_addr),
    .beat_o   (beat)
  );

  rts_strobe #(.MAX_CL(3)) u_stb (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cl3_i    (cfg_cas_lat == 2'd3),
    .beat_i   (beat),
    .strobe_o (rd_capture)
  );
endmodule

// File: tb/tb_rd_trunc_sched.sv
module tb_rd_trunc_sched;
  localparam int CLK_PERIOD = 10;
  localparam int TRP = 3;
  localparam int BL  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_cas_lat = 2'd2;
  logic        cfg_full_page = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_bank = '0;
  logic [7:0]  req_col = '0;
  logic [7:0]  req_beats = '0;
  logic        req_end_bst = 1'b0;
  logic        req_autopre = 1'b0;
  logic        req_reject;
  logic [3:0]  sd_cmd;
  logic [1:0]  sd_ba;
  logic [12:0] sd_addr;
  logic        rd_capture;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rd_trunc_sched dut (
    .clk(clk), .rst_n(rst_n), .cfg_cas_lat(cfg_cas_lat), .cfg_full_page(cfg_full_page),
    .req_valid(req_valid), .req_ready(req_ready), .req_bank(req_bank), .req_col(req_col),
    .req_beats(req_beats), .req_end_bst(req_end_bst), .req_autopre(req_autopre),
    .req_reject(req_reject), .sd_cmd(sd_cmd), .sd_ba(sd_ba), .sd_addr(sd_addr),
    .rd_capture(rd_capture)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int eff_n(int beats, bit full, bit ap);
    if (ap) return BL;
    if (!full && beats > BL) return BL;
    return beats;
  endfunction

  function automatic bit refused(int beats, bit bst, bit ap, bit full);
    return (beats == 0) || (ap && (bst || full));
  endfunction

  task automatic run_req(int bank, int col, int beats, bit bst, bit ap, int cl, bit full);
    int n, r, last, clv;
    logic [3:0] ecmd;
    logic [12:0] eaddr;
    logic [1:0] eba;
    string ct;
    while (req_ready !== 1'b1) @(negedge clk);
    cfg_cas_lat   = 2'(cl);
    cfg_full_page = full;
    req_bank      = 2'(bank);
    req_col       = 8'(col);
    req_beats     = 8'(beats);
    req_end_bst   = bst;
    req_autopre   = ap;
    req_valid     = 1'b1;
    @(posedge clk);
    if (refused(beats, bst, ap, full)) begin
      @(negedge clk);
      req_valid = 1'b0;
      chk("R9 reject pulse", 32'(req_reject), 32'd1);
      chk("R9 no command", 32'(sd_cmd), 32'h7);
      chk("R9 ready held", 32'(req_ready), 32'd1);
      @(negedge clk);
      chk("R9 pulse ends", 32'(req_reject), 32'd0);
      chk("R9 still idle", 32'(sd_cmd), 32'h7);
      return;
    end
    clv  = (cl == 3) ? 3 : 2;
    n    = eff_n(beats, full, ap);
    r    = bst ? n : ((TRP <= 1) ? n : n + TRP - 1);
    last = ((r > clv + n - 1) ? r : clv + n - 1) + 2;
    for (int j = 0; j <= last; j++) begin
      @(negedge clk);
      if (j == 0) req_valid = 1'b0;
      ecmd = 4'h7; eaddr = '0; eba = '0; ct = "R10 idle cycle";
      if (j == 0) begin
        ecmd = 4'h5; eaddr = 13'(col) | (13'(ap) << 10); eba = 2'(bank); ct = "R2 read";
      end else if (j == n) begin
        if (bst) begin ecmd = 4'h6; ct = "R4 terminate"; end
        else if (ap) begin ct = "R7 no end cmd"; end
        else begin ecmd = 4'h2; eba = 2'(bank); ct = "R3 precharge"; end
      end
      chk({ct, " cmd"}, 32'(sd_cmd), 32'(ecmd));
      chk({ct, " addr"}, 32'(sd_addr), 32'(eaddr));
      chk({ct, " ba"}, 32'(sd_ba), 32'(eba));
      chk((beats != n) ? (ap ? "R7 strobe count" : "R6 clamp strobe") : "R5 strobe",
          32'(rd_capture), 32'((j >= clv) && (j <= clv + n - 1)));
      chk(ap ? "R7 ready timing" : "R8 ready", 32'(req_ready), 32'(j >= r));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", 32'(req_ready), 32'd1);
    chk("R1 nop in reset", 32'(sd_cmd), 32'h7);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 ready", 32'(req_ready), 32'd1);
    chk("R1 nop", 32'(sd_cmd), 32'h7);
    chk("R1 addr", 32'(sd_addr), 32'd0);
    chk("R1 ba", 32'(sd_ba), 32'd0);
    chk("R1 strobe", 32'(rd_capture), 32'd0);

    // directed corners
    run_req(1, 8'h12, 2, 0, 0, 2, 0);   // R3 short precharge, CL2
    run_req(2, 8'h34, 2, 0, 0, 3, 0);   // R3 same count, CL3
    run_req(3, 8'hF0, 1, 1, 0, 3, 1);   // R4 single beat terminate
    run_req(0, 8'h01, 1, 0, 0, 2, 0);   // R3 single beat precharge
    run_req(2, 8'h40, 4, 0, 1, 3, 0);   // R7 auto precharge
    run_req(2, 8'h40, 4, 0, 0, 3, 0);   // R7 reference explicit precharge
    run_req(1, 8'h80, 7, 0, 0, 2, 0);   // R6 clamp fixed mode
    run_req(1, 8'h80, 12, 1, 0, 2, 1);  // R6 full page long terminate
    run_req(0, 8'h05, 0, 0, 0, 2, 0);   // R9 zero beats
    run_req(0, 8'h05, 3, 1, 1, 2, 0);   // R9 autopre with terminate
    run_req(0, 8'h05, 3, 0, 1, 2, 1);   // R9 autopre in full page

    for (int i = 0; i < 60; i++) begin
      bit full, bst, ap;
      int beats, cl;
      full  = 1'($urandom % 2);
      bst   = 1'($urandom % 2);
      ap    = (($urandom % 4) == 0);
      cl    = (($urandom % 2) == 0) ? 2 : 3;
      beats = (($urandom % 10) == 0) ? 0 : 1 + int'($urandom % (full ? 20 : 6));
      run_req(int'($urandom % 4), int'($urandom % 256), beats, bst, ap, cl, full);
    end

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule